// File: doc/BRIEF.md
# Isochronous Period Tracker with Offset Alignment

This block keeps a free-running isochronous period for a device or a fan-out bridge. The period is counted in common clocks, and a one-cycle pulse marks the start of each period. Isochronous requests are granted against a fixed budget that is refilled at every period start. This keeps the requester under its agreed maximum number of transactions per period.

To line its period up with an upstream partner, the block raises an alignment request and waits for the handshake. It then watches for the first data phase of the reply. The low byte of that reply word gives the number of clocks from that data phase to the partner's next period start. The block reloads its counter so that its own period start falls on that clock, plus a fixed extra shift that a bridge can set by parameter. A reply that carries the no-period code, or an offset outside the legal range, leaves the counter running as before and sets an unaligned flag.

Top module: `iso_period_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `periodStart` is 1, `alignReq` is 0, `unaligned` is 1 and `reqGrant` is 0 when `reqValid` is 0.
- R2: With no realignment, `periodStart` pulses for one cycle every PERIOD_LEN cycles.
- R3: A pulse on `alignStart` while idle raises `alignReq` in the next cycle. `alignReq` stays high until a cycle in which `alignAck` is high, and it is low in the cycle after that one.
- R4: `alignStart` is ignored while a request or a reply is outstanding, and `alignReq` stays low while the reply is awaited.
- R5: On a `replyFirst` cycle of an awaited reply whose low byte k is 0x00..0x41, `periodStart` pulses exactly k+1+DOWN_SHIFT cycles after that cycle, and every PERIOD_LEN cycles after that. `unaligned` reads 0 from the next cycle.
- R6: Only bits 7:0 of `replyData` are used. A reply of 0xABCDEF05 behaves exactly like 0x05.
- R7: A low byte of 0xFF (no period kept by the partner) leaves the period cadence unchanged and sets `unaligned` to 1.
- R8: A low byte of 0x42..0xFE leaves the period cadence unchanged and sets `unaligned` to 1.
- R9: A `replyFirst` pulse while no reply is awaited changes neither the cadence nor `unaligned`.
- R10: `reqGrant` is high only with `reqValid`, and at most BUDGET grants are made between two period starts.
- R11: The budget refills on every `periodStart` cycle, including one produced by a realignment. A request in that cycle is granted and counts toward the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rstN | input | 1 | Active-low synchronous reset |
| alignStart | input | 1 | Pulse that starts an alignment |
| alignReq | output | 1 | Alignment transaction request |
| alignAck | input | 1 | Acceptance of the alignment request |
| replyData | input | 32 | Reply word; only bits 7:0 carry the offset |
| replyFirst | input | 1 | Marks the first data phase of the reply |
| reqValid | input | 1 | Isochronous request wanting a slot |
| reqGrant | output | 1 | Request granted within the period budget |
| periodStart | output | 1 | One-cycle pulse at each period start |
| unaligned | output | 1 | Period not aligned to a partner |

## Verification
The in-line properties check these on every cycle: the wrap of the counter into a period start, the request hold and drop of the handshake, that a grant implies a request, that the used count never exceeds the budget, that a period start always frees a slot, and the free-running step plus flag set after a rejected offset. What needs the scenarios is the exact placement of period starts after a reply for several offsets, the masking of the upper reply bytes, the ignoring of stray replies and repeated start pulses, and the grant count over a full period.

// File: rtl/iso_align_pkg.sv
package iso_align_pkg;
  // Largest legal offset carried in the reply low byte
  localparam logic [7:0] MAX_OFFSET = 8'h41;

  // Strobes from alignment control to the period datapath
  typedef struct packed {
    logic       reAlign;   // load counter from offset
    logic       markLost;  // reply rejected, flag unaligned
    logic [7:0] offset;    // accepted offset in clocks
  } alignCmdT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } alignStateT;
endpackage

// File: rtl/iso_align_ctl.sv
module iso_align_ctl
  import iso_align_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        alignStart,
  input  logic        alignAck,
  input  logic [31:0] replyData,
  input  logic        replyFirst,
  output logic        alignReq,
  output alignCmdT    cmd
);
  alignStateT state, stateNext;
  logic [7:0] lowByte;
  logic       unusedUpper;

  assign lowByte     = replyData[7:0];
  assign unusedUpper = ^replyData[31:8];
  assign alignReq    = (state == ST_REQ);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (alignStart) stateNext = ST_REQ;
      ST_REQ:  if (alignAck)   stateNext = ST_WAIT;
      ST_WAIT: if (replyFirst) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd = '0;
    if (state == ST_WAIT && replyFirst) begin
      if (lowByte <= MAX_OFFSET) begin
        cmd.reAlign = 1'b1;
        cmd.offset  = lowByte;
      end else begin
        cmd.markLost = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R3
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alignReq && !alignAck) |=> alignReq);

  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alignReq && alignAck) |=> !alignReq);
endmodule

// File: rtl/iso_period_dp.sv
module iso_period_dp
  import iso_align_pkg::*;
#(
  parameter int PERIOD_LEN = 100,
  parameter int BUDGET     = 4,
  parameter int DOWN_SHIFT = 0
) (
  input  logic     clk,
  input  logic     rstN,
  input  alignCmdT cmd,
  input  logic     reqValid,
  output logic     reqGrant,
  output logic     periodStart,
  output logic     unaligned
);
  localparam int CW = (PERIOD_LEN > 1) ? $clog2(PERIOD_LEN) : 1;
  localparam int UW = $clog2(BUDGET + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_LEN - 1);

  logic [CW-1:0] cnt, loadVal;
  logic [UW-1:0] usedCnt, effUsed;
  int            shiftSum;

  // Offset counts from the reply data phase; zero starts a period next cycle
  always_comb begin
    shiftSum = int'(cmd.offset) + DOWN_SHIFT;
    if (shiftSum == 0) loadVal = '0;
    else               loadVal = CW'(PERIOD_LEN - shiftSum);
  end

  assign periodStart = (cnt == '0);
  assign effUsed     = periodStart ? '0 : usedCnt;
  assign reqGrant    = reqValid && (effUsed < UW'(BUDGET));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      usedCnt   <= '0;
      unaligned <= 1'b1;
    end else begin
      if (cmd.reAlign)      cnt <= loadVal;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + CW'(1);
      usedCnt <= effUsed + UW'(reqGrant);
      if (cmd.reAlign)       unaligned <= 1'b0;
      else if (cmd.markLost) unaligned <= 1'b1;
    end
  end

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == LAST && !cmd.reAlign) |=> periodStart);

  // R10
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |-> reqValid);

  // R10
  budget_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    usedCnt <= UW'(BUDGET));

  // R11
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodStart && reqValid) |-> reqGrant);

  // R8
  lost_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.markLost |=> unaligned &&
      cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + CW'(1)));

  // R5
  realign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.reAlign |=> !unaligned);
endmodule

// File: rtl/iso_period_tracker.sv
module iso_period_tracker
  import iso_align_pkg::*;
#(
  parameter int PERIOD_LEN = 100,
  parameter int BUDGET     = 4,
  parameter int DOWN_SHIFT = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        alignStart,
  output logic        alignReq,
  input  logic        alignAck,
  input  logic [31:0] replyData,
  input  logic        replyFirst,
  input  logic        reqValid,
  output logic        reqGrant,
  output logic        periodStart,
  output logic        unaligned
);
  alignCmdT cmd;

  iso_align_ctl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .alignStart (alignStart),
    .alignAck   (alignAck),
    .replyData  (replyData),
    .replyFirst (replyFirst),
    .alignReq   (alignReq),
    .cmd        (cmd)
  );

  iso_period_dp #(
    .PERIOD_LEN (PERIOD_LEN),
    .BUDGET     (BUDGET),
    .DOWN_SHIFT (DOWN_SHIFT)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .reqValid    (reqValid),
    .reqGrant    (reqGrant),
    .periodStart (periodStart),
    .unaligned   (unaligned)
  );
endmodule

// File: tb/sim_iso_period_tracker.sv
`timescale 1ns/1ps
module sim_iso_period_tracker;
  localparam int P  = 80;
  localparam int BG = 3;
  localparam int DS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic alignStart = 1'b0, alignAck = 1'b0, replyFirst = 1'b0, reqValid = 1'b0;
  logic [31:0] replyData = '0;
  logic alignReq, reqGrant, periodStart, unaligned;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  int lastPulse = 0;

  typedef struct { int at; string tag; } expT;
  expT expQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iso_period_tracker #(.PERIOD_LEN(P), .BUDGET(BG), .DOWN_SHIFT(DS)) u0 (
    .clk(clk), .rstN(rstN), .alignStart(alignStart), .alignReq(alignReq),
    .alignAck(alignAck), .replyData(replyData), .replyFirst(replyFirst),
    .reqValid(reqValid), .reqGrant(reqGrant), .periodStart(periodStart),
    .unaligned(unaligned));

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: compare each period start against the scoreboard front
  always @(negedge clk) begin
    if (rstN && periodStart) begin
      lastPulse = cyc;
      if (expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        chk(e.tag, cyc, e.at);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic drain();
    while (expQ.size() > 0) step();
  endtask

  // Driver: full alignment exchange, pushing the expected period starts
  task automatic doAlign(logic [31:0] word, int ackDelay, string tag);
    int c;
    int k;
    k = int'(word[7:0]);
    alignStart = 1'b1;
    step();
    alignStart = 1'b0;
    chk("R3 req raised", int'(alignReq), 1);
    for (int i = 0; i < ackDelay; i++) begin
      step();
      chk("R3 req held", int'(alignReq), 1);
    end
    alignAck = 1'b1;
    step();
    alignAck = 1'b0;
    chk("R3 req dropped", int'(alignReq), 0);
    alignStart = 1'b1;
    step();
    alignStart = 1'b0;
    chk("R4 start ignored while waiting", int'(alignReq), 0);
    c = cyc;
    if (k <= 8'h41) begin
      expQ.push_back('{c + 1 + k + DS, tag});
      expQ.push_back('{c + 1 + k + DS + P, tag});
    end else begin
      expQ.push_back('{lastPulse + P, tag});
    end
    replyData  = word;
    replyFirst = 1'b1;
    step();
    replyFirst = 1'b0;
    replyData  = '0;
    chk({tag, " unaligned flag"}, int'(unaligned), (k <= 8'h41) ? 0 : 1);
  endtask

  task automatic syncPulse();
    step();
    while (!periodStart) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int grants;
    int r;
    repeat (3) step();
    rstN = 1'b1;
    r = cyc;
    // R1 reset state
    chk("R1 periodStart", int'(periodStart), 1);
    chk("R1 alignReq", int'(alignReq), 0);
    chk("R1 unaligned", int'(unaligned), 1);
    chk("R1 reqGrant", int'(reqGrant), 0);
    // R2 free-running cadence
    expQ.push_back('{r + P, "R2"});
    expQ.push_back('{r + 2 * P, "R2"});
    drain();

    doAlign(32'h0000_0000, 2, "R5 offset 0");
    drain();
    doAlign(32'h0000_0041, 0, "R5 offset 0x41");
    drain();
    doAlign(32'hABCD_EF05, 1, "R6 upper bytes");
    drain();
    doAlign(32'h0000_00FF, 0, "R7 no-period code");
    drain();
    doAlign(32'h0000_002A, 0, "R5 offset 0x2A");
    drain();
    doAlign(32'h1234_5642, 3, "R8 out of range");
    drain();

    // R9 stray reply while idle
    repeat (3) step();
    expQ.push_back('{lastPulse + P, "R9 stray reply"});
    replyData  = 32'h0000_0000;
    replyFirst = 1'b1;
    step();
    replyFirst = 1'b0;
    chk("R9 unaligned kept", int'(unaligned), 1);
    drain();

    // R10 budget over one full period, R11 refill at next start
    syncPulse();
    reqValid = 1'b1;
    #1;
    grants = 0;
    for (int i = 0; i < P; i++) begin
      if (reqGrant) grants++;
      step();
    end
    chk("R10 grants per period", grants, BG);
    chk("R11 refill at period start", int'(reqGrant), 1);
    reqValid = 1'b0;
    #1;
    chk("R10 no grant without request", int'(reqGrant), 0);

    // R11 refill on a realignment-produced start
    syncPulse();
    reqValid = 1'b1;
    repeat (BG + 1) step();
    chk("R10 budget exhausted", int'(reqGrant), 0);
    doAlign(32'h0000_0000, 0, "R11 realign start");
    repeat (DS) step();
    chk("R11 realign periodStart", int'(periodStart), 1);
    chk("R11 grant after realign", int'(reqGrant), 1);
    reqValid = 1'b0;
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule